// File: doc/BRIEF.md
# Single-wire pulse-width bus host

This block is the controller end of a shared, active-low, single-wire bus with a pull-up. Each symbol on the wire is a low pulse, and the length of the pulse carries its meaning: a short pulse is a zero, a middle-length pulse is a one, and a long pulse is a frame marker. A very short read prompt lets a target device answer on the same wire.

The block takes one high-level request at a time through a valid/ready handshake. The request carries an opcode, a 4-bit target address, a data word and a bit count. From it, the block produces complete frames. Each frame is a marker, a 3-bit command, a payload, and then a closing marker followed by three ones. Between symbols the line is released for a minimum time. Addressed writes and reads get an address frame in front of them without being asked.

For a read, the block sends one prompt per bit and then lets go of the line. It samples the target's answer at a fixed point after the prompt's falling edge, and keeps off the wire until the target has had time to release it. The returned bits are collected LSB first and presented with a one-cycle done strobe. All durations are parameters counted in system-clock cycles.

Top module: `pwbus_host`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_drive_low` is 0, `rd_done` is 0 and `rd_data` is all zeros.
- R2: The line is driven low for exactly ZERO_CYC cycles for a zero bit, ONE_CYC cycles for a one bit, and MARK_CYC cycles for a frame marker.
- R3: Between any two low pulses, the line is released for at least GAP_CYC cycles.
- R4: Every frame is sent in this order: a marker, three command bits, the payload, a marker, and then one, one, one. The command bits are sent left to right. The codes are broadcast 000, write 001, address 010 and read 101.
- R5: `req_op` is decoded as follows: 0 is broadcast, 1 is address-select, 2 is addressed write, 3 is read, and 4 is software reset. Opcodes 1, 2 and 3 send an address frame whose payload is the 4 bits of `req_addr`, LSB first. For opcodes 2 and 3, the write or read frame follows the address frame directly. A broadcast sends no address frame.
- R6: A write or broadcast payload carries the `req_len` low bits of `req_data`, LSB first. A `req_len` of 0, or any value above DATA_W, is treated as DATA_W.
- R7: A software reset is a broadcast frame of DATA_W one bits, whatever the values of `req_data` and `req_len`.
- R8: A read payload is one prompt per bit. For each prompt the line is driven low for PROMPT_CYC cycles and then released. `bus_in` is sampled SAMPLE_CYC cycles after the prompt's first low cycle. The line is not driven again until at least RECLAIM_CYC cycles after that first low cycle.
- R9: Read bit k, in the order sampled, goes to `rd_data[k]`, and the bits above the count are zero. `rd_done` is high for exactly one cycle: the first cycle in which `req_ready` is back at 1. `rd_data` holds the new word in that cycle.
- R10: A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the last gap of the final frame has run out. `req_valid` has no effect while `req_ready` is 0.
- R11: Opcodes 5 to 7 are taken and dropped. No pulse is sent and `req_ready` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all durations are counted in its cycles |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The host is idle and will take a request |
| req_op | input | 3 | Opcode (see R5, R11) |
| req_addr | input | 4 | Target address for address, write and read |
| req_data | input | DATA_W | Word to send for write and broadcast |
| req_len | input | LEN_W | Bit count for write, broadcast and read |
| bus_in | input | 1 | Sensed level of the wire |
| bus_drive_low | output | 1 | Open-drain pull-down enable; 1 pulls the wire low |
| rd_data | output | DATA_W | Word collected by the last read |
| rd_done | output | 1 | One-cycle strobe marking a completed read |

## Verification
Each symbol starts one cycle after the sequencer enters its state. It therefore starts GAP_CYC+1 released cycles after the previous symbol ends, or RECLAIM_CYC-PROMPT_CYC+1 cycles after a prompt. For this reason the bench measures pulse widths and gaps as cycle counts, sampled on the falling clock edge, rather than at fixed times.

`req_ready` must be 0 at the first falling edge after the accepting edge. `rd_done` and the new `rd_data` must be present at the same falling edge where `req_ready` is first seen high again, so both are checked at that sample.

The bench's target model counts cycles from each prompt's first low cycle. It holds the wire low for a zero answer from cycle PROMPT_CYC through cycle RECLAIM_CYC-3, a window that contains the sampling cycle on both sides.

// File: rtl/pwbus_pkg.sv
package pwbus_pkg;

    localparam int ADDR_BITS = 4;
    localparam int CMD_BITS  = 3;

    // Request opcodes seen on req_op
    typedef enum logic [2:0] {
        OP_BCAST = 3'd0,
        OP_ADDR  = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_RESET = 3'd4
    } op_e;

    // Wire symbols
    typedef enum logic [1:0] {
        SYM_ZERO,
        SYM_ONE,
        SYM_MARK,
        SYM_PROMPT
    } sym_e;

    // Frame sequencer states
    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD_MARK,
        S_CMD,
        S_BODY,
        S_TAIL_MARK,
        S_TAIL_ONES
    } seq_state_e;

    // Command codes, sent from bit 2 down to bit 0
    localparam logic [CMD_BITS-1:0] CMD_BCAST = 3'b000;
    localparam logic [CMD_BITS-1:0] CMD_WRITE = 3'b001;
    localparam logic [CMD_BITS-1:0] CMD_ADDR  = 3'b010;
    localparam logic [CMD_BITS-1:0] CMD_READ  = 3'b101;

endpackage

// File: rtl/pwbus_symbol_gen.sv
module pwbus_symbol_gen
    import pwbus_pkg::*;
#(
    parameter int ZERO_CYC    = 500,
    parameter int ONE_CYC     = 3000,
    parameter int MARK_CYC    = 10000,
    parameter int GAP_CYC     = 50,
    parameter int PROMPT_CYC  = 100,
    parameter int SAMPLE_CYC  = 350,
    parameter int RECLAIM_CYC = 1300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  sym_e kind,
    output logic busy,
    output logic done,
    output logic drive,
    output logic sample
);

    localparam int LONG_PULSE = MARK_CYC + GAP_CYC;
    localparam int LONGEST    = (LONG_PULSE > RECLAIM_CYC) ? LONG_PULSE : RECLAIM_CYC;
    localparam int CW         = $clog2(LONGEST + 1);

    localparam logic [CW-1:0] W_ZERO   = CW'(ZERO_CYC);
    localparam logic [CW-1:0] W_ONE    = CW'(ONE_CYC);
    localparam logic [CW-1:0] W_MARK   = CW'(MARK_CYC);
    localparam logic [CW-1:0] W_PROMPT = CW'(PROMPT_CYC);
    localparam logic [CW-1:0] T_ZERO   = CW'(ZERO_CYC + GAP_CYC);
    localparam logic [CW-1:0] T_ONE    = CW'(ONE_CYC + GAP_CYC);
    localparam logic [CW-1:0] T_MARK   = CW'(MARK_CYC + GAP_CYC);
    localparam logic [CW-1:0] T_PROMPT = CW'(RECLAIM_CYC);
    localparam logic [CW-1:0] C_SAMPLE = CW'(SAMPLE_CYC);

    logic          active_q;
    sym_e          kind_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] width_c;
    logic [CW-1:0] total_c;

    always_comb begin
        unique case (kind_q)
            SYM_ZERO:   begin width_c = W_ZERO;   total_c = T_ZERO;   end
            SYM_ONE:    begin width_c = W_ONE;    total_c = T_ONE;    end
            SYM_MARK:   begin width_c = W_MARK;   total_c = T_MARK;   end
            SYM_PROMPT: begin width_c = W_PROMPT; total_c = T_PROMPT; end
            default:    begin width_c = W_ZERO;   total_c = T_ZERO;   end
        endcase
    end

    assign busy   = active_q;
    assign done   = active_q && (cnt_q == total_c - CW'(1));
    assign drive  = active_q && (cnt_q < width_c);
    assign sample = active_q && (kind_q == SYM_PROMPT) && (cnt_q == C_SAMPLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            kind_q   <= SYM_ZERO;
            cnt_q    <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                kind_q   <= kind;
                cnt_q    <= '0;
            end
        end else if (done) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R8: the host is off the wire when it samples the answer
    a_r8_released_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !drive);

    // R3: every low pulse is followed by released time
    a_r3_gap_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive) |=> !drive);

    // R2: a pulse, once started, lasts past its first cycle
    a_r2_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active_q) |=> drive);

endmodule

// File: rtl/pwbus_rx_shift.sv
module pwbus_rx_shift #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word
);

    localparam int IW = $clog2(DATA_W + 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            idx_q <= '0;
        end else if (clear) begin
            word  <= '0;
            idx_q <= '0;
        end else if (sample && (idx_q < IW'(DATA_W))) begin
            for (int k = 0; k < DATA_W; k++) begin
                if (idx_q == IW'(k)) begin
                    word[k] <= bit_in;
                end
            end
            idx_q <= idx_q + IW'(1);
        end
    end

    // R9: never more samples than the word holds
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clear) |-> (idx_q < IW'(DATA_W)));

endmodule

// File: rtl/pwbus_host.sv
module pwbus_host
    import pwbus_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int LEN_W       = $clog2(DATA_W + 1),
    parameter int ZERO_CYC    = 500,
    parameter int ONE_CYC     = 3000,
    parameter int MARK_CYC    = 10000,
    parameter int GAP_CYC     = 50,
    parameter int PROMPT_CYC  = 100,
    parameter int SAMPLE_CYC  = 350,
    parameter int RECLAIM_CYC = 1300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [DATA_W-1:0]    req_data,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 bus_in,
    output logic                 bus_drive_low,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_done
);

    localparam int IDX_W = (LEN_W > CMD_BITS) ? LEN_W : CMD_BITS;
    localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_BITS - 1);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_BITS - 1);

    seq_state_e           state_q, state_d;
    logic [IDX_W-1:0]     idx_q, idx_d;
    logic                 frame_addr_q, frame_addr_d;
    logic                 launch_q, launch_d;
    op_e                  op_q;
    logic [ADDR_BITS-1:0] addr_q;
    logic [DATA_W-1:0]    data_q;
    logic [LEN_W-1:0]     nbits_q;

    logic                 accept;
    logic                 op_known;
    logic                 take;
    logic                 want_addr;
    logic [LEN_W-1:0]     eff_len;
    logic [CMD_BITS-1:0]  cur_cmd;
    logic [CMD_BITS-1:0]  cmd_sh;
    logic [DATA_W-1:0]    data_sh;
    logic [ADDR_BITS-1:0] addr_sh;
    logic [IDX_W-1:0]     body_last;
    logic                 chain_next;
    logic                 frame_end;
    logic                 rd_done_d;
    logic                 is_read_body;

    sym_e                 sym_kind;
    logic                 sym_busy;
    logic                 sym_done;
    logic                 sym_sample;
    logic [DATA_W-1:0]    rx_word;

    // ---------------- request decode ----------------
    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign op_known  = (req_op <= 3'd4);
    assign take      = accept && op_known;
    assign want_addr = (req_op == OP_WRITE) || (req_op == OP_READ) || (req_op == OP_ADDR);

    always_comb begin
        eff_len = req_len;
        if ((req_len == '0) || (req_len > LEN_W'(DATA_W))) begin
            eff_len = LEN_W'(DATA_W);
        end
    end

    // ---------------- frame fields ----------------
    always_comb begin
        if (frame_addr_q) begin
            cur_cmd = CMD_ADDR;
        end else begin
            unique case (op_q)
                OP_WRITE: cur_cmd = CMD_WRITE;
                OP_READ:  cur_cmd = CMD_READ;
                default:  cur_cmd = CMD_BCAST;
            endcase
        end
    end

    assign cmd_sh       = cur_cmd << idx_q;
    assign data_sh      = data_q >> idx_q;
    assign addr_sh      = addr_q >> idx_q;
    assign body_last    = frame_addr_q ? ADDR_LAST : (IDX_W'(nbits_q) - IDX_W'(1));
    assign chain_next   = frame_addr_q && ((op_q == OP_WRITE) || (op_q == OP_READ));
    assign is_read_body = !frame_addr_q && (op_q == OP_READ);
    assign frame_end    = (state_q == S_TAIL_ONES) && sym_done && (idx_q == CMD_LAST);
    assign rd_done_d    = frame_end && is_read_body;

    // ---------------- next state ----------------
    always_comb begin
        state_d      = state_q;
        idx_d        = idx_q;
        frame_addr_d = frame_addr_q;
        launch_d     = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (take) begin
                    state_d      = S_LEAD_MARK;
                    idx_d        = '0;
                    frame_addr_d = want_addr;
                    launch_d     = 1'b1;
                end
            end
            S_LEAD_MARK: begin
                if (sym_done) begin
                    state_d  = S_CMD;
                    idx_d    = '0;
                    launch_d = 1'b1;
                end
            end
            S_CMD: begin
                if (sym_done) begin
                    launch_d = 1'b1;
                    if (idx_q == CMD_LAST) begin
                        state_d = S_BODY;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            S_BODY: begin
                if (sym_done) begin
                    launch_d = 1'b1;
                    if (idx_q == body_last) begin
                        state_d = S_TAIL_MARK;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
            end
            S_TAIL_MARK: begin
                if (sym_done) begin
                    state_d  = S_TAIL_ONES;
                    idx_d    = '0;
                    launch_d = 1'b1;
                end
            end
            S_TAIL_ONES: begin
                if (sym_done) begin
                    if (idx_q == CMD_LAST) begin
                        idx_d = '0;
                        if (chain_next) begin
                            state_d      = S_LEAD_MARK;
                            frame_addr_d = 1'b0;
                            launch_d     = 1'b1;
                        end else begin
                            state_d      = S_IDLE;
                            frame_addr_d = 1'b0;
                        end
                    end else begin
                        idx_d    = idx_q + IDX_W'(1);
                        launch_d = 1'b1;
                    end
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // ---------------- symbol selection (outputs) ----------------
    always_comb begin
        unique case (state_q)
            S_LEAD_MARK, S_TAIL_MARK: sym_kind = SYM_MARK;
            S_CMD:                    sym_kind = cmd_sh[CMD_BITS-1] ? SYM_ONE : SYM_ZERO;
            S_BODY: begin
                if (is_read_body) begin
                    sym_kind = SYM_PROMPT;
                end else if (frame_addr_q) begin
                    sym_kind = addr_sh[0] ? SYM_ONE : SYM_ZERO;
                end else begin
                    sym_kind = data_sh[0] ? SYM_ONE : SYM_ZERO;
                end
            end
            S_TAIL_ONES:              sym_kind = SYM_ONE;
            default:                  sym_kind = SYM_ZERO;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            idx_q        <= '0;
            frame_addr_q <= 1'b0;
            launch_q     <= 1'b0;
            op_q         <= OP_BCAST;
            addr_q       <= '0;
            data_q       <= '0;
            nbits_q      <= '0;
            rd_done      <= 1'b0;
            rd_data      <= '0;
        end else begin
            state_q      <= state_d;
            idx_q        <= idx_d;
            frame_addr_q <= frame_addr_d;
            launch_q     <= launch_d;
            rd_done      <= rd_done_d;
            if (rd_done_d) begin
                rd_data <= rx_word;
            end
            if (take) begin
                op_q    <= op_e'(req_op);
                addr_q  <= req_addr;
                data_q  <= (req_op == OP_RESET) ? '1 : req_data;
                nbits_q <= (req_op == OP_RESET) ? LEN_W'(DATA_W) : eff_len;
            end
        end
    end

    // ---------------- submodules ----------------
    pwbus_symbol_gen #(
        .ZERO_CYC    (ZERO_CYC),
        .ONE_CYC     (ONE_CYC),
        .MARK_CYC    (MARK_CYC),
        .GAP_CYC     (GAP_CYC),
        .PROMPT_CYC  (PROMPT_CYC),
        .SAMPLE_CYC  (SAMPLE_CYC),
        .RECLAIM_CYC (RECLAIM_CYC)
    ) i_symbol_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (launch_q),
        .kind   (sym_kind),
        .busy   (sym_busy),
        .done   (sym_done),
        .drive  (bus_drive_low),
        .sample (sym_sample)
    );

    pwbus_rx_shift #(
        .DATA_W (DATA_W)
    ) i_rx_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (take),
        .sample (sym_sample),
        .bit_in (bus_in),
        .word   (rx_word)
    );

    // ---------------- assertions ----------------
    // R10: busy from the cycle after a request is taken
    a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !req_ready);

    // R11: dropped opcodes leave the host idle
    a_r11_unknown_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !op_known) |=> req_ready);

    // R9: the done strobe is one cycle long and coincides with ready
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
    a_r9_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> req_ready);

    // R1: an idle host never pulls the wire
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_drive_low);

    // R2: a symbol is launched only into an idle generator
    a_r2_launch_into_idle: assert property (@(posedge clk) disable iff (!rst_n)
        launch_q |-> !sym_busy);

endmodule

// File: tb/test_pwbus_host.sv
module test_pwbus_host;

    localparam int DATA_W  = 8;
    localparam int LEN_W   = 4;
    localparam int ZERO    = 10;
    localparam int ONE     = 30;
    localparam int MARK    = 60;
    localparam int GAP     = 3;
    localparam int PROMPT  = 2;
    localparam int SAMPLE  = 6;
    localparam int RECLAIM = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = 3'd0;
    logic [3:0]        req_addr = 4'd0;
    logic [DATA_W-1:0] req_data = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              bus_in;
    logic              bus_drive_low;
    logic [DATA_W-1:0] rd_data;
    logic              rd_done;
    logic              tgt_low = 1'b0;

    int nchk  = 0;
    int nfail = 0;

    // monitor state
    int pw[64];
    int npw = 0;
    int run = 0;
    int gap = 0;
    int min_gap = 1000000;
    int min_pgap = 1000000;
    bit started = 0;
    bit after_prompt = 0;
    bit prev_drv = 0;

    // target model state
    logic [DATA_W-1:0] tgt_word = '0;
    int  pc = 0;
    bit  in_prompt = 0;
    int  tbit = 0;
    int  cur_bit = 0;

    // expected sequence
    int exp_w[64];
    int nexp = 0;
    bit done_at_ready = 0;

    assign bus_in = ~(bus_drive_low | tgt_low);

    always #5 clk = ~clk;

    pwbus_host #(
        .DATA_W      (DATA_W),
        .LEN_W       (LEN_W),
        .ZERO_CYC    (ZERO),
        .ONE_CYC     (ONE),
        .MARK_CYC    (MARK),
        .GAP_CYC     (GAP),
        .PROMPT_CYC  (PROMPT),
        .SAMPLE_CYC  (SAMPLE),
        .RECLAIM_CYC (RECLAIM)
    ) i_pwbus_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_op        (req_op),
        .req_addr      (req_addr),
        .req_data      (req_data),
        .req_len       (req_len),
        .bus_in        (bus_in),
        .bus_drive_low (bus_drive_low),
        .rd_data       (rd_data),
        .rd_done       (rd_done)
    );

    // pulse monitor and target model, away from the active edge
    always @(negedge clk) begin
        if (bus_drive_low) begin
            if (!prev_drv) begin
                if (started && gap < min_gap) min_gap = gap;
                if (after_prompt && gap < min_pgap) min_pgap = gap;
                pc = 0;
                in_prompt = 0;
            end else begin
                pc = pc + 1;
            end
            run = run + 1;
            gap = 0;
        end else begin
            if (prev_drv) begin
                if (npw < 64) pw[npw] = run;
                npw = npw + 1;
                after_prompt = (run == PROMPT);
                run = 0;
                started = 1;
            end
            gap = gap + 1;
            pc = pc + 1;
            if (pc == PROMPT && after_prompt) begin
                in_prompt = 1;
                cur_bit = tbit;
                tbit = tbit + 1;
            end
        end
        prev_drv = bus_drive_low;
        tgt_low = in_prompt && (pc >= PROMPT) && (pc <= RECLAIM - 3)
                  && (cur_bit < DATA_W) && !tgt_word[cur_bit % DATA_W];
    end

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    task automatic mon_clear();
        npw = 0;
        min_gap = 1000000;
        min_pgap = 1000000;
        started = 0;
        after_prompt = 0;
        tbit = 0;
        nexp = 0;
    endtask

    task automatic exp_sym(input int w);
        if (nexp < 64) exp_w[nexp] = w;
        nexp++;
    endtask

    task automatic exp_frame(input logic [2:0] cmd, input logic [31:0] pay, input int n, input bit prompts);
        exp_sym(MARK);
        for (int k = 2; k >= 0; k--) exp_sym(cmd[k] ? ONE : ZERO);
        for (int k = 0; k < n; k++) exp_sym(prompts ? PROMPT : (pay[k] ? ONE : ZERO));
        exp_sym(MARK);
        for (int k = 0; k < 3; k++) exp_sym(ONE);
    endtask

    task automatic check_pulses(input string req);
        int bad;
        bad = -1;
        chk(npw == nexp, {req, " pulse count"}, npw, nexp);
        for (int i = 0; i < npw && i < nexp && i < 64; i++) begin
            if (bad < 0 && pw[i] != exp_w[i]) bad = i;
        end
        if (bad >= 0) chk(1'b0, {req, " pulse width"}, pw[bad], exp_w[bad]);
        else          chk(1'b1, {req, " pulse width"}, 0, 0);
        // R3: released time between pulses
        chk(min_gap >= GAP, "R3 minimum gap", min_gap, GAP);
    endtask

    task automatic run_req(input logic [2:0] op, input logic [3:0] a,
                           input logic [DATA_W-1:0] d, input logic [LEN_W-1:0] len);
        int w;
        @(negedge clk);
        mon_clear();
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_data  = d;
        req_len   = len;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10 ready low after take", int'(req_ready), 0);
        w = 0;
        while (!req_ready && w < 20000) begin
            @(negedge clk);
            w++;
        end
        done_at_ready = rd_done;
    endtask

    task automatic t_reset_state();
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(bus_drive_low == 1'b0, "R1 line released after reset", int'(bus_drive_low), 0);
        chk(rd_done == 1'b0, "R1 done low after reset", int'(rd_done), 0);
        chk(rd_data == '0, "R1 read data zero after reset", int'(rd_data), 0);
    endtask

    task automatic t_broadcast();
        run_req(3'd0, 4'h9, 8'hA5, 4'd8);
        exp_frame(3'b000, 32'hA5, 8, 0);
        check_pulses("R2 R4 R6 broadcast A5");
        chk(done_at_ready == 1'b0, "R9 no done after broadcast", int'(done_at_ready), 0);
    endtask

    task automatic t_address();
        run_req(3'd1, 4'h6, 8'hFF, 4'd8);
        exp_frame(3'b010, 32'h6, 4, 0);
        check_pulses("R5 address select 6");
    endtask

    task automatic t_write();
        run_req(3'd2, 4'hB, 8'h13, 4'd5);
        exp_frame(3'b010, 32'hB, 4, 0);
        exp_frame(3'b001, 32'h13, 5, 0);
        check_pulses("R5 R6 addressed write");
    endtask

    task automatic t_read(input logic [DATA_W-1:0] word, input logic [LEN_W-1:0] len,
                          input logic [DATA_W-1:0] expect_word);
        tgt_word = word;
        run_req(3'd3, 4'h3, 8'h00, len);
        exp_frame(3'b010, 32'h3, 4, 0);
        exp_frame(3'b101, 32'h0, int'(len), 1);
        check_pulses("R8 read frames");
        chk(min_pgap >= RECLAIM - PROMPT, "R8 reclaim after prompt", min_pgap, RECLAIM - PROMPT);
        chk(done_at_ready == 1'b1, "R9 done with ready", int'(done_at_ready), 1);
        chk(rd_data == expect_word, "R9 read word", int'(rd_data), int'(expect_word));
        @(negedge clk);
        chk(rd_done == 1'b0, "R9 done one cycle", int'(rd_done), 0);
        tgt_word = '0;
    endtask

    task automatic t_soft_reset();
        run_req(3'd4, 4'h0, 8'h12, 4'd3);
        exp_frame(3'b000, 32'hFF, DATA_W, 0);
        check_pulses("R7 software reset ones");
    endtask

    task automatic t_len_clamp();
        run_req(3'd0, 4'h0, 8'h6C, 4'd0);
        exp_frame(3'b000, 32'h6C, DATA_W, 0);
        check_pulses("R6 length zero clamps");
        run_req(3'd0, 4'h0, 8'h81, 4'd12);
        exp_frame(3'b000, 32'h81, DATA_W, 0);
        check_pulses("R6 length above width clamps");
    endtask

    task automatic t_busy_ignore();
        int w;
        @(negedge clk);
        mon_clear();
        req_valid = 1'b1;
        req_op = 3'd0; req_data = 8'h0F; req_len = 4'd4;
        @(negedge clk);
        req_op = 3'd3; req_data = 8'hF0; req_addr = 4'h5;
        w = 0;
        while (!req_ready && w < 20000) begin
            @(negedge clk);
            w++;
        end
        req_valid = 1'b0;
        exp_frame(3'b000, 32'h0F, 4, 0);
        check_pulses("R10 valid ignored while busy");
        repeat (20) @(negedge clk);
        chk(npw == nexp, "R10 no extra frame", npw, nexp);
        chk(req_ready == 1'b1, "R10 ready after busy test", int'(req_ready), 1);
    endtask

    task automatic t_bad_op();
        @(negedge clk);
        mon_clear();
        req_valid = 1'b1;
        req_op = 3'd6;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b1, "R11 ready stays high", int'(req_ready), 1);
        repeat (30) @(negedge clk);
        chk(npw == 0, "R11 no pulse for unknown opcode", npw, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_broadcast();
        t_address();
        t_write();
        t_read(8'h3C, 4'd8, 8'h3C);
        t_read(8'hF6, 4'd5, 8'h16);
        t_soft_reset();
        t_len_clamp();
        t_busy_ignore();
        t_bad_op();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule